// File: doc/BRIEF.md
# Erasable Byte Memory Behavioural Model

This block is a clocked, synthesizable stand-in for a programmable read-only byte memory whose cells can only be cleared by programming and restored by a bulk erase. All control inputs are sampled on the rising clock. Each cycle they select one operating mode: read, output off, standby, program, verify, program inhibit or identifier readout. The result appears one clock later on a registered data output, together with a drive-enable flag for an external tri-state buffer. Two level flags stand in for the analog conditions of the real part. `vpp_hi` means the programming supply is raised. `a9_hv` means a high voltage is present on address bit 9.

The full-size part has `ADDR_W = 13`, which gives 8192 bytes. The default of `ADDR_W = 11` gives 2048 bytes and keeps elaboration small. Reset, and an `erase` pulse, both start a sweep that writes all-ones into the array one address per clock. `busy` is high while the sweep runs. The `ERASABLE` parameter chooses between the window-erasable variant and a one-time variant. In the one-time variant the `erase` pin has no effect, but the array still starts blank after reset.

Top module: `erasable_prom`

## Requirements
- R1: Reset starts a blank sweep. `busy` is 1 during reset and stays 1 for exactly DEPTH = 2^ADDR_W clocks after release. Afterwards every address reads 8'hFF.
- R2: A program operation stores the old byte AND `din`. It can clear bits but never set them, and one low pulse of `prog_n` writes exactly once, on its falling edge.
- R3: Data is driven (`dout_en` = 1) only when both `ce_n` and `oe_n` were low in the previous cycle. When not driving, `dout` is 8'h00. In read mode (`vpp_hi` = 0, `a9_hv` = 0) the stored byte appears one clock after the address is presented.
- R4: With `ce_n` high (standby), `dout_en` is 0 on the next cycle whatever `oe_n` is.
- R5: A write happens only when `ce_n` is low, `vpp_hi` is 1 and `prog_n` falls. A strobe with `vpp_hi` = 0 leaves the byte unchanged.
- R6: Verify mode (`vpp_hi` = 1, `ce_n` = 0, `oe_n` = 0, `prog_n` = 1) drives the stored byte.
- R7: Program inhibit (`vpp_hi` = 1, `ce_n` = 1) ignores a strobe pulse. No cell changes.
- R8: Identifier mode (`a9_hv` = 1, `vpp_hi` = 0, `ce_n` = `oe_n` = 0) returns 8'h9B when `addr[0]` = 0 and 8'h08 when `addr[0]` = 1. All other address bits are ignored.
- R9: With `ERASABLE` = 1, a one-cycle `erase` pulse sets `busy` for exactly DEPTH clocks and leaves every byte 8'hFF. While `busy` is high, a further erase, a program strobe and a read request are all ignored, and `dout_en` stays 0.
- R10: With `ERASABLE` = 0, `erase` is ignored: `busy` stays 0 and the stored data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the blank sweep |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_n | input | 1 | Program strobe, active low, acts on its falling edge |
| din | input | DATA_W | Data to program |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | High voltage on address bit 9 (identifier request) |
| erase | input | 1 | Bulk erase request, one-cycle pulse |
| dout | output | DATA_W | Registered read data, zero when not driving |
| dout_en | output | 1 | Drive enable for an external tri-state buffer |
| busy | output | 1 | Blank sweep in progress |

## Verification
Several rules are checked by assertions on every cycle:
- output drive only after both enables were low, and silence after standby;
- silence during a sweep;
- identifier output restricted to the two codes;
- a verify cycle leading to drive;
- a program write never turning a 0 into a 1;
- a sweep that ends with its end cells blank;
- the one-time variant never starting a sweep.

Only the bench scenarios can show the rest. These are the exact stored values after repeated programming, the absence of a write under a missing supply or under inhibit, and the exact sweep length. They also include an erase or a strobe issued in the middle of a sweep being dropped, and a stored byte surviving an erase request on the one-time variant.

// File: rtl/emr_pkg.sv
package emr_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_INHIBIT,
      MD_OUTOFF,
      MD_READ,
      MD_IDENT,
      MD_PROGRAM,
      MD_VERIFY,
      MD_SWEEP
   } emr_mode_e;

   function automatic logic mode_drives(input emr_mode_e m);
      return (m == MD_READ) || (m == MD_IDENT) || (m == MD_VERIFY);
   endfunction

endpackage

// File: rtl/emr_mode_dec.sv
module emr_mode_dec
   import emr_pkg::*;
(
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      prog_n,
   input  logic      vpp_hi,
   input  logic      a9_hv,
   input  logic      busy,
   output emr_mode_e mode
);

   always_comb begin
      if (busy) begin
         mode = MD_SWEEP;
      end else if (ce_n) begin
         mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
      end else if (vpp_hi) begin
         if (!prog_n)      mode = MD_PROGRAM;
         else if (!oe_n)   mode = MD_VERIFY;
         else              mode = MD_OUTOFF;
      end else if (oe_n) begin
         mode = MD_OUTOFF;
      end else if (a9_hv) begin
         mode = MD_IDENT;
      end else begin
         mode = MD_READ;
      end
   end

endmodule

// File: rtl/emr_id_rom.sv
module emr_id_rom #(
   parameter int                DATA_W = 8,
   parameter logic [DATA_W-1:0] ID_LO  = 8'h9B,
   parameter logic [DATA_W-1:0] ID_HI  = 8'h08
) (
   input  logic              sel,
   output logic [DATA_W-1:0] code
);

   assign code = sel ? ID_HI : ID_LO;

endmodule

// File: rtl/emr_cell_array.sv
module emr_cell_array #(
   parameter int ADDR_W   = 11,
   parameter int DATA_W   = 8,
   parameter bit ERASABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              wr_req,
   input  logic              erase_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);

   localparam int              DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] ptr;
   logic              sweep_q;
   logic              erase_go;
   logic [DATA_W-1:0] cur_byte;

   assign cur_byte = mem[addr];
   assign busy     = sweep_q;

   generate
      if (ERASABLE) begin : g_uv
         assign erase_go = erase_req && !sweep_q;
      end else begin : g_otp
         assign erase_go = 1'b0;
         // R10: the one-time variant never starts a sweep from the pin
         assert_otp_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!sweep_q && erase_req) |=> !sweep_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sweep_q <= 1'b1;
         ptr     <= '0;
      end else if (sweep_q) begin
         if (ptr == LAST) sweep_q <= 1'b0;
         ptr <= ptr + 1'b1;
      end else if (erase_go) begin
         sweep_q <= 1'b1;
         ptr     <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (sweep_q) begin
         mem[ptr] <= '1;
      end else if (wr_req) begin
         mem[addr] <= cur_byte & din;
      end
      rd_data <= mem[addr];
   end

   // R2: a program write may only clear bits
   assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !sweep_q) |=> ((mem[$past(addr)] & ~$past(cur_byte)) == '0));

   // R1: a finished sweep leaves both end cells blank
   assert_sweep_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sweep_q) |-> (mem[LAST] == '1 && mem[0] == '1));

endmodule

// File: rtl/erasable_prom.sv
module erasable_prom
   import emr_pkg::*;
#(
   parameter int                ADDR_W   = 11,
   parameter int                DATA_W   = 8,
   parameter bit                ERASABLE = 1'b1,
   parameter logic [DATA_W-1:0] ID_LO    = 8'h9B,
   parameter logic [DATA_W-1:0] ID_HI    = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              prog_n,
   input  logic [DATA_W-1:0] din,
   input  logic              vpp_hi,
   input  logic              a9_hv,
   input  logic              erase,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              busy
);

   generate
      if (ADDR_W < 10 || ADDR_W > 16) begin : g_bad_addr
         $error("erasable_prom: ADDR_W must lie in 10..16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("erasable_prom: DATA_W must be positive");
      end
   endgenerate

   emr_mode_e         mode;
   logic              prog_q;
   logic              wr_req;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] id_code;
   logic [DATA_W-1:0] id_q;
   logic              drv_q;
   logic              id_sel_q;

   emr_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .prog_n (prog_n),
      .vpp_hi (vpp_hi),
      .a9_hv  (a9_hv),
      .busy   (busy),
      .mode   (mode)
   );

   // falling edge of the strobe inside program mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prog_q <= 1'b0;
      else        prog_q <= prog_n;
   end
   assign wr_req = (mode == MD_PROGRAM) && prog_q;

   emr_cell_array #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ERASABLE (ERASABLE)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .din       (din),
      .wr_req    (wr_req),
      .erase_req (erase),
      .rd_data   (rd_data),
      .busy      (busy)
   );

   emr_id_rom #(
      .DATA_W (DATA_W),
      .ID_LO  (ID_LO),
      .ID_HI  (ID_HI)
   ) u_id (
      .sel  (addr[0]),
      .code (id_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q    <= 1'b0;
         id_sel_q <= 1'b0;
         id_q     <= '0;
      end else begin
         drv_q    <= mode_drives(mode);
         id_sel_q <= (mode == MD_IDENT);
         id_q     <= id_code;
      end
   end

   assign dout_en = drv_q;
   assign dout    = drv_q ? (id_sel_q ? id_q : rd_data) : '0;

   // R3: driving needs both enables low one cycle earlier
   assert_both_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> $past(!ce_n && !oe_n));

   // R4: standby silences the outputs
   assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !dout_en);

   // R6: a verify cycle drives
   assert_verify_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ce_n && !oe_n && vpp_hi && prog_n) |=> dout_en);

   // R8: identifier readout yields one of the two codes
   assert_id_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en && $past(a9_hv && !vpp_hi)) |-> (dout == ID_LO || dout == ID_HI));

   // R9: nothing is driven while the sweep runs
   assert_busy_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !dout_en);

endmodule

// File: tb/tb_erasable_prom.sv
module tb_erasable_prom;

   localparam int AW    = 11;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1, oe_n = 1'b1, prog_n = 1'b1;
   logic [7:0]    din = '0;
   logic          vpp_hi = 1'b0, a9_hv = 1'b0;
   logic          erase = 1'b0, erase_o = 1'b0;
   logic [7:0]    dout, otp_dout;
   logic          dout_en, busy, otp_en, otp_busy;

   always #2.5 clk = ~clk;

   erasable_prom #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .prog_n(prog_n), .din(din), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
      .erase(erase), .dout(dout), .dout_en(dout_en), .busy(busy));

   erasable_prom #(.ADDR_W(AW), .ERASABLE(1'b0)) dut_otp (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .prog_n(prog_n), .din(din), .vpp_hi(vpp_hi), .a9_hv(a9_hv),
      .erase(erase_o), .dout(otp_dout), .dout_en(otp_en), .busy(otp_busy));

   typedef struct {
      int         due;
      logic       drv;
      logic [7:0] val;
      string      tag;
   } exp_t;

   exp_t       q[$];
   exp_t       e;
   int         cyc = 0;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;
   logic [7:0] model [DEPTH];

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expectations that fall due on this cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         e = q.pop_front();
         checks++;
         if (dout_en !== e.drv || dout !== (e.drv ? e.val : 8'h00)) begin
            errors++;
            $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                     e.tag, dout_en, dout, e.drv, e.drv ? e.val : 8'h00);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h, expected %0h", tag, act, expv);
      end
   endtask

   // driver: one cycle of stimulus, optionally queuing the expected result
   task automatic step(input logic c, input logic o, input logic p, input logic v,
                       input logic h, input logic [AW-1:0] a, input logic [7:0] d,
                       input bit want, input logic xd, input logic [7:0] xv,
                       input string tag);
      @(negedge clk);
      ce_n = c; oe_n = o; prog_n = p; vpp_hi = v; a9_hv = h; addr = a; din = d;
      if (want) q.push_back('{cyc + 1, xd, xv, tag});
   endtask

   task automatic idle();
      step(1, 1, 1, 0, 0, '0, 8'h00, 0, 0, 8'h00, "");
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      step(0, 0, 1, 0, 0, a, 8'h00, 1, 1, model[a], tag);
   endtask

   task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
      step(0, 1, 0, 1, 0, a, d, 0, 0, 8'h00, "");
      step(0, 1, 0, 1, 0, a, d, 0, 0, 8'h00, "");
      step(0, 1, 1, 1, 0, a, d, 0, 0, 8'h00, "");
      model[a] = model[a] & d;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #750000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int n;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dout_en === 1'b0 && dout === 8'h00, "R1 reset outputs", dout_en, 0);
      chk(busy === 1'b1, "R1 busy in reset", busy, 1);
      rst_n = 1'b1;
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk(n == DEPTH, "R1 sweep length", n, DEPTH);
      rd(0, "R1 blank low");
      rd(AW'(DEPTH - 1), "R1 blank high");
      rd(AW'(333), "R1 blank mid");

      // R2/R6: program, verify, program again
      idle();
      prog(5, 8'hA5);
      step(0, 0, 1, 1, 0, 5, 8'h00, 1, 1, 8'hA5, "R6 verify A5");
      prog(5, 8'h3C);
      step(0, 0, 1, 1, 0, 5, 8'h00, 1, 1, 8'h24, "R2 AND result");
      rd(5, "R3 read programmed byte");
      idle();
      prog(9, 8'h0F);
      prog(9, 8'hF0);
      rd(9, "R2 cleared bits stay clear");

      // R5: strobe without programming supply
      step(0, 1, 0, 0, 0, 6, 8'h00, 0, 0, 8'h00, "");
      step(0, 1, 1, 0, 0, 6, 8'h00, 0, 0, 8'h00, "");
      rd(6, "R5 no write without supply");

      // R7: inhibit
      step(1, 1, 0, 1, 0, 7, 8'h00, 0, 0, 8'h00, "");
      step(1, 1, 1, 1, 0, 7, 8'h00, 0, 0, 8'h00, "");
      rd(7, "R7 inhibit keeps byte");

      // R4/R3: standby and output off
      step(1, 0, 1, 0, 0, 5, 8'h00, 1, 0, 8'h00, "R4 standby oe low");
      step(1, 1, 1, 0, 0, 5, 8'h00, 1, 0, 8'h00, "R4 standby oe high");
      step(0, 1, 1, 0, 0, 5, 8'h00, 1, 0, 8'h00, "R3 output off");

      // R8: identifier
      step(0, 0, 1, 0, 1, AW'(0), 8'h00, 1, 1, 8'h9B, "R8 id low");
      step(0, 0, 1, 0, 1, AW'(1), 8'h00, 1, 1, 8'h08, "R8 id high");
      step(0, 0, 1, 0, 1, AW'(12'h5FE), 8'h00, 1, 1, 8'h9B, "R8 id upper bits ignored even");
      step(0, 0, 1, 0, 1, AW'(12'h3A5), 8'h00, 1, 1, 8'h08, "R8 id upper bits ignored odd");
      step(0, 1, 1, 0, 1, AW'(0), 8'h00, 1, 0, 8'h00, "R8 id needs oe");
      idle();
      repeat (2) @(negedge clk);

      // R9: erase with disturbances during the sweep
      erase = 1'b1;
      @(negedge clk);
      erase = 1'b0;
      n = 0;
      while (busy) begin
         n++;
         if (n == 10) erase = 1'b1;
         if (n == 11) erase = 1'b0;
         if (n == 50) begin ce_n = 0; oe_n = 0; addr = 5; end
         if (n == 51) chk(dout_en === 1'b0, "R9 no drive while busy", dout_en, 0);
         if (n == 52) begin ce_n = 1; oe_n = 1; end
         if (n == 100) begin ce_n = 0; vpp_hi = 1; prog_n = 0; addr = 0; din = 8'h00; end
         if (n == 101) begin ce_n = 1; vpp_hi = 0; prog_n = 1; end
         @(negedge clk);
      end
      chk(n == DEPTH, "R9 erase length", n, DEPTH);
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      rd(0, "R9 strobe during sweep dropped");
      rd(5, "R9 programmed byte erased");
      rd(9, "R9 second byte erased");
      idle();

      // R10: one-time variant ignores erase
      erase_o = 1'b1;
      @(negedge clk);
      erase_o = 1'b0;
      @(negedge clk);
      chk(otp_busy === 1'b0, "R10 otp busy stays low", otp_busy, 0);
      step(0, 0, 1, 0, 0, 5, 8'h00, 0, 0, 8'h00, "");
      @(negedge clk);
      chk(otp_en === 1'b1 && otp_dout === 8'h24, "R10 otp keeps data", otp_dout, 8'h24);
      idle();
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule